// File: doc/BRIEF.md
# Regulator Control Register Bank

This block is the byte-wide configuration store of a programmable step-down regulator. A serial host interface drives its write/read bus. The bus has four byte locations: two output-voltage words, a primary control byte and a secondary control byte. From these stored fields the block drives the digital flags that the analog regulator consumes:
- the gated enable,
- the selected target code,
- the forced-PWM versus automatic PFM/PWM choice,
- the discharge enable,
- the slew-rate code.

The target can be chosen in two ways. In pin control, an external select pin picks between the two voltage words, and the outputs follow the pin at once. In software control, the host writes word 1 and then sets a start bit. A small transfer state machine then captures word 1 as the new target and issues a one-cycle request to the ramp engine. The start bit reads as 1 until the ramp engine reports completion.

The machine has three states:
- `S_IDLE`: no transition is in flight.
- `S_REQ`: the request cycle.
- `S_RAMP`: waiting for the ramp engine.

It has three transitions:
- T_ACCEPT (`S_IDLE` to `S_REQ`): a start write while software control is selected.
- T_ISSUED (`S_REQ` to `S_RAMP`): taken when no done is seen.
- T_DONE (`S_REQ` or `S_RAMP` to `S_IDLE`): taken on `ramp_done`.

Top module: `regctl_bank`

## Requirements
- R1: After reset, the reads return the following values (with `pwr_good` = 0):
  - address 0: 0xC0
  - address 1: 0xC0
  - address 2: 0xB0
  - address 3: 0x47

  The outputs are `slew_code` = 7, `discharge_en` = 1, `target_code` = 0 and `xfer_req` = 0.
- R2: Bit 7 of address 0 and bit 7 of address 1 are one shared enable flag. A write to either address sets it, and both addresses read back the new value.
- R3: `reg_enable` is 1 only when the shared enable flag is 1 and `pin_en` is 1.
- R4: Addresses 0 and 1 store a 6-bit code in bits 5:0. Bit 6 always reads 1, whatever was written.
- R5: In address 2, bits 7:6 always read binary 10 and bit 5 always reads 1. Writes to these bits are ignored. Bits 4:0 store the written value: bit 4 is the control source, bits 3:2 the mode field, bit 1 the word-1 mode bit and bit 0 the word-0 mode bit.
- R6: With the control source = 1 (pin control), `target_code` follows the select pin without a clock edge. It is word 1 when `pin_vsel` is high and word 0 when it is low.
- R7: With the control source = 0 (software control), `target_code` is the word-1 code captured when a start is accepted. Later writes to word 1 do not change it until the next accepted start.
- R8: `forced_pwm` is decoded from the mode field:
  - 10: 1.
  - 01 or 11: 0.
  - 00: if the output is driven from word 1 (software control, or `pin_vsel` high), it is the inverse of the word-1 mode bit; otherwise it is 0.
- R9: In address 3, bit 6 is the discharge enable and bits 2:0 are the slew code; both are stored and drive `discharge_en` and `slew_code`. Bit 5 reads `pwr_good`, and bits 4:3 read 0. Writes to bits 5:3 are ignored.
- R10: Writing address 3 with bit 7 = 1, in software control while idle, makes bit 7 read 1 from the next cycle. It also raises `xfer_req` for exactly that one cycle.
- R11: A start write is ignored in pin control: no request is made and bit 7 stays 0. A start write while a transition is in flight causes no second request.
- R12: Once set, bit 7 of address 3 stays 1 until `ramp_done` is seen, including during the request cycle. It then reads 0 from the next cycle. Writing 0 to bit 7 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 2 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_en | input | 1 | External enable pin |
| pin_vsel | input | 1 | External voltage-select pin |
| pwr_good | input | 1 | Regulation status from the analog side |
| ramp_done | input | 1 | Ramp engine reports the transition has ended |
| reg_enable | output | 1 | Gated regulator enable |
| target_code | output | 6 | Selected output-voltage code |
| forced_pwm | output | 1 | 1 = forced PWM, 0 = automatic PFM/PWM |
| discharge_en | output | 1 | Output discharge enable |
| slew_code | output | 3 | Slew-rate code |
| xfer_req | output | 1 | One-cycle transition request to the ramp engine |

## Verification
The assertions watch, on every cycle:
- that the transfer request lasts a single cycle;
- that a pin-controlled start never produces one;
- that the busy flag holds until done and falls right after it;
- that the shared enable flag takes the written bit;
- that the gated enable never rises without the pin;
- that the software-mode target holds still between accepted starts;
- that the output stays automatic while word 0 drives it.

Only the bench's scenarios can show the full byte-level picture. That covers reserved and read-only bits, the complete mode decode across all control bytes and both select levels, the pin-mode target mux, and the ordering of start, rewrite, clear attempt and done.

// File: rtl/regctl_pkg.sv
package regctl_pkg;
    localparam int DATA_W   = 8;
    localparam int DAC_W    = 6;
    localparam int ADDR_W   = 2;
    localparam int NUM_VSEL = 2;
    localparam int SLEW_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL_A = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_CTRL_B = ADDR_W'(3);
    localparam logic [1:0]        ID_FIELD    = 2'b10;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RAMP = 2'd2
    } xfer_state_t;

    typedef enum logic [1:0] {
        MF_DEFER  = 2'b00,
        MF_AUTO_A = 2'b01,
        MF_PWM    = 2'b10,
        MF_AUTO_B = 2'b11
    } mode_field_t;

    // Bit order matches the low five bits of control byte A.
    typedef struct packed {
        logic        src_pin;
        mode_field_t mode_field;
        logic        mode_w1;
        logic        mode_w0;
    } ctrl_a_t;
endpackage

// File: rtl/regctl_volt_words.sv
module regctl_volt_words
    import regctl_pkg::*;
#(
    parameter logic             RST_EN  = 1'b1,
    parameter logic [DAC_W-1:0] RST_DAC = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             wr_en_bit,
    input  logic [DAC_W-1:0]                 wr_code,
    output logic                             en_flag,
    output logic [NUM_VSEL-1:0][DAC_W-1:0]   codes
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(NUM_VSEL - 1);

    logic hit_any;
    assign hit_any = we && (addr <= LAST_WORD);

    // One flop serves bit 7 of every voltage word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_flag <= RST_EN;
        end else if (hit_any) begin
            en_flag <= wr_en_bit;
        end
    end

    for (genvar i = 0; i < NUM_VSEL; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                codes[i] <= RST_DAC;
            end else if (we && (addr == ADDR_W'(i))) begin
                codes[i] <= wr_code;
            end
        end
    end

    AST_SHARED_EN: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> (en_flag == $past(wr_en_bit)));  // R2
endmodule

// File: rtl/regctl_ctrl_words.sv
module regctl_ctrl_words
    import regctl_pkg::*;
#(
    parameter logic              RST_SRC_PIN    = 1'b1,
    parameter logic [1:0]        RST_MODE_FIELD = 2'b00,
    parameter logic              RST_MODE_W1    = 1'b0,
    parameter logic              RST_MODE_W0    = 1'b0,
    parameter logic              RST_DISCHARGE  = 1'b1,
    parameter logic [SLEW_W-1:0] RST_SLEW       = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        wr_ctrl_a,
    input  logic              wr_discharge,
    input  logic [SLEW_W-1:0] wr_slew,
    output ctrl_a_t           ctrl_a,
    output logic              discharge,
    output logic [SLEW_W-1:0] slew
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a.src_pin    <= RST_SRC_PIN;
            ctrl_a.mode_field <= mode_field_t'(RST_MODE_FIELD);
            ctrl_a.mode_w1    <= RST_MODE_W1;
            ctrl_a.mode_w0    <= RST_MODE_W0;
        end else if (we && (addr == ADDR_CTRL_A)) begin
            ctrl_a <= ctrl_a_t'(wr_ctrl_a);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            discharge <= RST_DISCHARGE;
            slew      <= RST_SLEW;
        end else if (we && (addr == ADDR_CTRL_B)) begin
            discharge <= wr_discharge;
            slew      <= wr_slew;
        end
    end
endmodule

// File: rtl/regctl_mode_dec.sv
module regctl_mode_dec
    import regctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ctrl_a_t ctrl_a,
    input  logic    pin_vsel,
    output logic    use_word1,
    output logic    forced_pwm
);
    always_comb begin
        use_word1 = !ctrl_a.src_pin || pin_vsel;
        unique case (ctrl_a.mode_field)
            MF_PWM:               forced_pwm = 1'b1;
            MF_AUTO_A, MF_AUTO_B: forced_pwm = 1'b0;
            MF_DEFER:             forced_pwm = use_word1 ? !ctrl_a.mode_w1 : 1'b0;
            default:              forced_pwm = 1'b0;
        endcase
    end

    AST_AUTO_ON_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a.src_pin && !pin_vsel && (ctrl_a.mode_field != MF_PWM)) |-> !forced_pwm);  // R8
endmodule

// File: rtl/regctl_xfer_fsm.sv
module regctl_xfer_fsm
    import regctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic sw_ctrl,
    input  logic ramp_done,
    output logic busy,
    output logic xfer_req,
    output logic accept
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_wr && sw_ctrl) state_d = S_REQ;      // T_ACCEPT
            S_REQ:  state_d = ramp_done ? S_IDLE : S_RAMP;         // T_DONE / T_ISSUED
            S_RAMP: if (ramp_done) state_d = S_IDLE;               // T_DONE
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        xfer_req = (state_q == S_REQ);
        accept   = (state_q == S_IDLE) && start_wr && sw_ctrl;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);  // R10
    AST_PIN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_wr && !sw_ctrl) |=> !xfer_req);  // R11
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ramp_done) |=> !busy);  // R12
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ramp_done) |=> busy);  // R12
endmodule

// File: rtl/regctl_bank.sv
module regctl_bank
    import regctl_pkg::*;
#(
    parameter logic              RST_EN         = 1'b1,
    parameter logic              RST_SRC_PIN    = 1'b1,
    parameter logic [1:0]        RST_MODE_FIELD = 2'b00,
    parameter logic              RST_MODE_W1    = 1'b0,
    parameter logic              RST_MODE_W0    = 1'b0,
    parameter logic [SLEW_W-1:0] RST_SLEW       = 3'b111,
    parameter logic              RST_DISCHARGE  = 1'b1,
    parameter logic [DAC_W-1:0]  RST_DAC        = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_en,
    input  logic              pin_vsel,
    input  logic              pwr_good,
    input  logic              ramp_done,
    output logic              reg_enable,
    output logic [DAC_W-1:0]  target_code,
    output logic              forced_pwm,
    output logic              discharge_en,
    output logic [SLEW_W-1:0] slew_code,
    output logic              xfer_req
);
    logic                           en_flag;
    logic [NUM_VSEL-1:0][DAC_W-1:0] codes;
    ctrl_a_t                        ctrl_a;
    logic                           use_word1;
    logic                           busy;
    logic                           accept;
    logic                           start_wr;
    logic [DAC_W-1:0]               sw_target;

    regctl_volt_words #(
        .RST_EN  (RST_EN),
        .RST_DAC (RST_DAC)
    ) u_volt (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wr_en_bit (bus_wdata[7]),
        .wr_code   (bus_wdata[DAC_W-1:0]),
        .en_flag   (en_flag),
        .codes     (codes)
    );

    regctl_ctrl_words #(
        .RST_SRC_PIN    (RST_SRC_PIN),
        .RST_MODE_FIELD (RST_MODE_FIELD),
        .RST_MODE_W1    (RST_MODE_W1),
        .RST_MODE_W0    (RST_MODE_W0),
        .RST_DISCHARGE  (RST_DISCHARGE),
        .RST_SLEW       (RST_SLEW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (bus_we),
        .addr         (bus_addr),
        .wr_ctrl_a    (bus_wdata[4:0]),
        .wr_discharge (bus_wdata[6]),
        .wr_slew      (bus_wdata[SLEW_W-1:0]),
        .ctrl_a       (ctrl_a),
        .discharge    (discharge_en),
        .slew         (slew_code)
    );

    regctl_mode_dec u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_a     (ctrl_a),
        .pin_vsel   (pin_vsel),
        .use_word1  (use_word1),
        .forced_pwm (forced_pwm)
    );

    assign start_wr = bus_we && (bus_addr == ADDR_CTRL_B) && bus_wdata[7];

    regctl_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .sw_ctrl   (!ctrl_a.src_pin),
        .ramp_done (ramp_done),
        .busy      (busy),
        .xfer_req  (xfer_req),
        .accept    (accept)
    );

    // Software-mode target, captured from word 1 on an accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_target <= RST_DAC;
        end else if (accept) begin
            sw_target <= codes[1];
        end
    end

    always_comb begin
        if (ctrl_a.src_pin) begin
            target_code = use_word1 ? codes[1] : codes[0];
        end else begin
            target_code = sw_target;
        end
        reg_enable = en_flag && pin_en;
    end

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = {en_flag, 1'b1, codes[0]};
            2'd1:    bus_rdata = {en_flag, 1'b1, codes[1]};
            2'd2:    bus_rdata = {ID_FIELD, 1'b1, ctrl_a};
            2'd3:    bus_rdata = {busy, discharge_en, pwr_good, 2'b00, slew_code};
            default: bus_rdata = '0;
        endcase
    end

    AST_EN_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_enable |-> pin_en);  // R3
    AST_SW_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_a.src_pin && !accept) |=> (ctrl_a.src_pin || $stable(target_code)));  // R7
endmodule

// File: tb/regctl_bank_tb.sv
module regctl_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pin_en = 1'b0;
    logic       pin_vsel = 1'b0;
    logic       pwr_good = 1'b0;
    logic       ramp_done = 1'b0;
    logic       reg_enable;
    logic [5:0] target_code;
    logic       forced_pwm;
    logic       discharge_en;
    logic [2:0] slew_code;
    logic       xfer_req;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    regctl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_en(pin_en),
        .pin_vsel(pin_vsel), .pwr_good(pwr_good), .ramp_done(ramp_done),
        .reg_enable(reg_enable), .target_code(target_code), .forced_pwm(forced_pwm),
        .discharge_en(discharge_en), .slew_code(slew_code), .xfer_req(xfer_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic exp_pwm(input logic [4:0] c, input logic vsel);
        logic w1;
        w1 = !c[4] || vsel;
        case (c[3:2])
            2'b10:   return 1'b1;
            2'b01,
            2'b11:   return 1'b0;
            default: return w1 ? !c[1] : 1'b0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5:0] dac [2];
        logic       en;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pin_en = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 addr0", v, 8'hC0);
        rd(2'd1, v); chk("R1 addr1", v, 8'hC0);
        rd(2'd2, v); chk("R1 addr2", v, 8'hB0);
        rd(2'd3, v); chk("R1 addr3", v, 8'h47);
        chk("R1 slew", slew_code, 3'd7);
        chk("R1 discharge", discharge_en, 1'b1);
        chk("R1 target", target_code, 6'd0);
        chk("R1 xfer_req", xfer_req, 1'b0);

        // R2 / R4 sweep of every code on both words
        dac[0] = 6'd0; dac[1] = 6'd0; en = 1'b1;
        for (int code = 0; code < 64; code++) begin
            for (int a = 0; a < 2; a++) begin
                logic [5:0] c6;
                logic       b6;
                c6 = 6'(code);
                b6 = c6[1];
                en = c6[2] ^ a[0];
                dac[a] = c6;
                wr(2'(a), {en, b6, c6});
                rd(2'(a), v);
                chk("R4 word readback", v, {en, 1'b1, dac[a]});
                rd(2'(1 - a), v);
                chk("R2 shared enable", v, {en, 1'b1, dac[1 - a]});
            end
        end

        // R3 gated enable
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                wr(2'd0, {e[0], 7'd0});
                pin_en = p[0];
                #1;
                chk("R3 reg_enable", reg_enable, e[0] & p[0]);
            end
        end
        pin_en = 1'b1;

        // R5 control byte A, all 256 writes
        for (int d = 0; d < 256; d++) begin
            logic [7:0] d8;
            d8 = 8'(d);
            wr(2'd2, d8);
            rd(2'd2, v);
            chk("R5 ctrl A readback", v, {2'b10, 1'b1, d8[4:0]});
        end

        // R6 / R8 sweep of ctrl A low bits and both select levels
        wr(2'd0, 8'h95);
        wr(2'd1, 8'hAA);
        for (int c = 0; c < 32; c++) begin
            logic [4:0] c5;
            c5 = 5'(c);
            wr(2'd2, {3'b000, c5});
            for (int s = 0; s < 2; s++) begin
                pin_vsel = s[0];
                #1;
                chk("R8 forced_pwm", forced_pwm, exp_pwm(c5, s[0]));
                if (c5[4]) chk("R6 pin target", target_code, s[0] ? 6'h2A : 6'h15);
            end
        end
        pin_vsel = 1'b0;

        // R9 / R11 control byte B sweep in pin control
        wr(2'd2, 8'h10);
        for (int d = 0; d < 256; d++) begin
            logic [7:0] d8;
            d8 = 8'(d);
            pwr_good = d8[3];
            wr(2'd3, d8);
            chk("R11 no request in pin mode", xfer_req, 1'b0);
            rd(2'd3, v);
            chk("R9 ctrl B readback", v, {1'b0, d8[6], d8[3], 2'b00, d8[2:0]});
            chk("R9 discharge", discharge_en, d8[6]);
            chk("R9 slew", slew_code, d8[2:0]);
        end
        pwr_good = 1'b0;

        // R10 / R7 / R11 / R12 software transition sequence
        wr(2'd1, 8'h91);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h87);
        chk("R10 request pulse", xfer_req, 1'b1);
        chk("R7 captured target", target_code, 6'h11);
        rd(2'd3, v); chk("R10 start reads 1", v[7], 1'b1);
        @(negedge clk);
        chk("R10 request one cycle", xfer_req, 1'b0);
        rd(2'd3, v); chk("R12 start held", v[7], 1'b1);
        wr(2'd1, 8'hA2);
        chk("R7 target unchanged", target_code, 6'h11);
        wr(2'd3, 8'h87);
        chk("R11 no re-request while busy", xfer_req, 1'b0);
        wr(2'd3, 8'h07);
        rd(2'd3, v); chk("R12 zero write ignored", v[7], 1'b1);
        ramp_done = 1'b1;
        @(negedge clk);
        ramp_done = 1'b0;
        rd(2'd3, v); chk("R12 cleared by done", v[7], 1'b0);
        wr(2'd3, 8'h87);
        chk("R10 second request", xfer_req, 1'b1);
        chk("R7 new target", target_code, 6'h22);
        ramp_done = 1'b1;
        @(negedge clk);
        ramp_done = 1'b0;
        chk("R12 done in request cycle", xfer_req, 1'b0);
        rd(2'd3, v); chk("R12 cleared from request", v[7], 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule